// File: doc/BRIEF.md
# Pipelined Multi-Operand Carry-Save Adder

This block adds K unsigned M-bit operands and gives one N-bit sum that wraps modulo 2^N. The operands arrive together as one flat vector with a valid strobe. The block accepts a new set of operands on every clock cycle, and it has no stall or backpressure path.

Inside, the operand bits are sorted into columns by their binary weight. Column j holds bit j of every operand. Columns above the operand width start empty, and there are N columns in all. Each reduction level is a register stage, and each level compresses every column. Within a column, every group of three bits goes into a full adder. If two bits are left over, they go into a half adder. If one bit is left over, it passes through unchanged. A column keeps its own sum bits and takes in the carries from the column below it. Carries out of the top column are discarded.

The height of the next level is set by this rule: next = ceil(h/3) + floor(h/3), plus one more when h mod 3 is 2. Levels are added while the height is above two, and the number of levels is fixed when the design is elaborated. A registered carry-propagate adder then adds the last two rows.

Top module: `wal_multi_adder`

## Requirements
- R1: Each result marked valid equals the sum of the K operands presented with the matching input valid, reduced modulo 2^N.
- R2: The latency from input to output is the number of reduction levels plus one cycle. With the defaults (K=6) the levels have heights 6, 4, 3 and 2, so the latency is 3 + 1 = 4 cycles. For K of 1 or 2 the latency is 1 cycle.
- R3: `out_vld` repeats `in_vld` delayed by exactly the latency. Valid inputs on consecutive cycles give valid results on consecutive cycles, with no gap and no merging.
- R4: Sums that need more than N bits wrap. With the defaults and every operand at 255, the result is 1530 mod 1024 = 506.
- R5: Operand i occupies `in_ops[i*M +: M]`, so operand 0 sits in the least significant bits.
- R6: `rst_n` is an active-low asynchronous reset. While it is low, and after it is released until the first valid input has passed through the pipeline, `out_vld` stays low.
- R7: Each reduction level keeps the weighted sum of its bits, modulo 2^N, from input to registered output. It also leaves every slot at or above the level's input height at zero.
- R8: Operand data presented while `in_vld` is low produces no valid result at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Marks `in_ops` as a valid operand set |
| in_ops | input | K*M | Flat operand vector, operand i at bits i*M +: M |
| out_vld | output | 1 | Marks `out_sum` as a valid result |
| out_sum | output | N | Sum of the operands modulo 2^N |

## Verification
The assertions assume that the data beside a valid strobe is fully known. They also assume that the zero padding at each level boundary is present, which only the regrouping stage and the reduction levels themselves supply. The bench never raises the valid strobe while the operands are undriven. It holds the strobe low in the cycle when reset is released, so that no operand set is caught half inside reset. When the strobe is low it still drives random operands. This shows that unqualified data never reaches a valid result.

// File: rtl/wal_pkg.sv
package wal_pkg;

    // Height of a column after one 3:2 / 2:2 compression pass
    function automatic int wal_next_h(input int h);
        return (h + 2) / 3 + h / 3 + (((h % 3) == 2) ? 1 : 0);
    endfunction

    // Number of reduction levels needed for K operand rows
    function automatic int wal_levels(input int k);
        int h;
        int n;
        h = k;
        n = 0;
        for (int i = 0; i < 64; i++) begin
            if (h > 2) begin
                h = wal_next_h(h);
                n = n + 1;
            end
        end
        return n;
    endfunction

    // Column height at the input of a given level
    function automatic int wal_height(input int k, input int lvl);
        int h;
        h = k;
        for (int i = 0; i < 64; i++) begin
            if (i < lvl) h = wal_next_h(h);
        end
        return h;
    endfunction

endpackage

// File: rtl/wal_regroup.sv
module wal_regroup #(
    parameter int K = 6,
    parameter int M = 8,
    parameter int N = 10
) (
    input  logic [K*M-1:0] ops,
    output logic [N*K-1:0] cols
);
    // Column j, slot i carries bit j of operand i; columns at or above M are empty
    for (genvar j = 0; j < N; j++) begin : g_col
        for (genvar i = 0; i < K; i++) begin : g_row
            if (j < M) begin : g_bit
                assign cols[j*K+i] = ops[i*M+j];
            end else begin : g_pad
                assign cols[j*K+i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/wal_csa_level.sv
module wal_csa_level
    import wal_pkg::*;
#(
    parameter int N    = 10,
    parameter int K    = 6,
    parameter int H_IN = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vld_i,
    input  logic [N*K-1:0] cols_i,
    output logic           vld_o,
    output logic [N*K-1:0] cols_o
);
    localparam int NFA   = H_IN / 3;
    localparam int REM   = H_IN % 3;
    localparam int NS    = (H_IN + 2) / 3;
    localparam int H_OUT = wal_next_h(H_IN);
    localparam int HX    = (REM != 0) ? 3 * NFA : 0;
    localparam int HY    = (REM == 2) ? 3 * NFA + 1 : 0;
    localparam int CY    = (REM == 2) ? NS + NFA : 0;

    function automatic logic [N*K-1:0] pad_mask();
        logic [N*K-1:0] m;
        m = '0;
        for (int j = 0; j < N; j++)
            for (int i = 0; i < K; i++)
                if (i >= H_IN) m[j*K+i] = 1'b1;
        return m;
    endfunction

    localparam logic [N*K-1:0] PAD = pad_mask();

    logic [N*K-1:0] nxt;

    always_comb begin
        nxt = '0;
        // sums stay in their own column, slots 0 .. NS-1
        for (int j = 0; j < N; j++) begin
            for (int g = 0; g < NFA; g++) begin
                nxt[j*K+g] = cols_i[j*K+3*g] ^ cols_i[j*K+3*g+1] ^ cols_i[j*K+3*g+2];
            end
            if (REM == 2) begin
                nxt[j*K+NFA] = cols_i[j*K+HX] ^ cols_i[j*K+HY];
            end else if (REM == 1) begin
                nxt[j*K+NFA] = cols_i[j*K+HX];
            end
        end
        // carries move one column up, placed after the sums; top carries drop
        for (int j = 0; j < N - 1; j++) begin
            for (int g = 0; g < NFA; g++) begin
                nxt[(j+1)*K+NS+g] = (cols_i[j*K+3*g]   & cols_i[j*K+3*g+1]) |
                                    (cols_i[j*K+3*g]   & cols_i[j*K+3*g+2]) |
                                    (cols_i[j*K+3*g+1] & cols_i[j*K+3*g+2]);
            end
            if (REM == 2) begin
                nxt[(j+1)*K+CY] = cols_i[j*K+HX] & cols_i[j*K+HY];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= vld_i;
    end

    always_ff @(posedge clk) begin
        cols_o <= nxt;
    end

    function automatic logic [N-1:0] weigh(input logic [N*K-1:0] c);
        logic [N-1:0] acc;
        acc = '0;
        for (int j = 0; j < N; j++)
            for (int i = 0; i < K; i++)
                acc = acc + ({{(N-1){1'b0}}, c[j*K+i]} << j);
        return acc;
    endfunction

    a_r7_value_kept: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> weigh(cols_o) == $past(weigh(cols_i)));

    a_r7_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |-> (cols_i & PAD) == '0);

    a_r3_vld_carried: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> vld_o);

    a_r8_idle_carried: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> !vld_o);

    initial a_r7_height_shrinks: assert (H_OUT < H_IN || H_IN < 3);
endmodule

// File: rtl/wal_cpa_stage.sv
module wal_cpa_stage #(
    parameter int N = 10,
    parameter int K = 6,
    parameter int H = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vld_i,
    input  logic [N*K-1:0] cols_i,
    output logic           vld_o,
    output logic [N-1:0]   sum_o
);
    localparam int B1 = (H >= 2) ? 1 : 0;

    logic [N-1:0] row_a;
    logic [N-1:0] row_b;

    for (genvar j = 0; j < N; j++) begin : g_rows
        assign row_a[j] = cols_i[j*K];
        if (H >= 2) begin : g_two
            assign row_b[j] = cols_i[j*K+B1];
        end else begin : g_one
            assign row_b[j] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= vld_i;
    end

    always_ff @(posedge clk) begin
        sum_o <= row_a + row_b;
    end

    function automatic logic [N-1:0] weigh(input logic [N*K-1:0] c);
        logic [N-1:0] acc;
        acc = '0;
        for (int j = 0; j < N; j++)
            for (int i = 0; i < K; i++)
                acc = acc + ({{(N-1){1'b0}}, c[j*K+i]} << j);
        return acc;
    endfunction

    a_r1_cpa_sum: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> sum_o == $past(weigh(cols_i)));

    a_r1_sum_known: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> !$isunknown(sum_o));
endmodule

// File: rtl/wal_multi_adder.sv
module wal_multi_adder
    import wal_pkg::*;
#(
    parameter int K = 6,
    parameter int M = 8,
    parameter int N = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_vld,
    input  logic [K*M-1:0] in_ops,
    output logic           out_vld,
    output logic [N-1:0]   out_sum
);
    localparam int NLEV = wal_levels(K);
    localparam int LAT  = NLEV + 1;
    localparam int HFIN = wal_height(K, NLEV);

    logic [N*K-1:0] bus [NLEV+1];
    logic [NLEV:0]  vld_bus;

    wal_regroup #(.K(K), .M(M), .N(N)) u_regroup (
        .ops  (in_ops),
        .cols (bus[0])
    );
    assign vld_bus[0] = in_vld;

    for (genvar l = 0; l < NLEV; l++) begin : g_lvl
        wal_csa_level #(.N(N), .K(K), .H_IN(wal_height(K, l))) u_level (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld_i  (vld_bus[l]),
            .cols_i (bus[l]),
            .vld_o  (vld_bus[l+1]),
            .cols_o (bus[l+1])
        );
    end

    wal_cpa_stage #(.N(N), .K(K), .H(HFIN)) u_cpa (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (vld_bus[NLEV]),
        .cols_i (bus[NLEV]),
        .vld_o  (out_vld),
        .sum_o  (out_sum)
    );

    // In-flight tracker for the pipeline-depth checks
    int unsigned pend;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= 0;
        else        pend <= pend + 32'(in_vld) - 32'(out_vld);
    end

    a_r3_no_orphan: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> pend != 0);

    a_r2_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= LAT);
endmodule

// File: tb/tb_wal_multi_adder.sv
module tb_wal_multi_adder;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int K   = 6;
    localparam int M   = 8;
    localparam int N   = 10;
    localparam int LAT = 4;   // R2: three levels plus the final adder
    localparam int HW  = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_vld = 1'b0;
    logic [K*M-1:0] in_ops = '0;
    logic           out_vld;
    logic [N-1:0]   out_sum;

    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;
    bit    done   = 1'b0;
    logic         h_vld [HW];
    logic [N-1:0] h_sum [HW];
    string        h_tag [HW];

    always #2.5 clk = ~clk;

    wal_multi_adder #(.K(K), .M(M), .N(N)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_vld),
        .in_ops  (in_ops),
        .out_vld (out_vld),
        .out_sum (out_sum)
    );

    function automatic logic [N-1:0] ref_sum(input logic [K*M-1:0] ops);
        int s = 0;
        for (int i = 0; i < K; i++) s += int'(ops[i*M +: M]);
        return N'(s);
    endfunction

    function automatic logic [K*M-1:0] rnd_ops();
        logic [K*M-1:0] v;
        for (int i = 0; i < K; i++) v[i*M +: M] = M'($urandom);
        return v;
    endfunction

    task automatic step(input logic v, input logic [K*M-1:0] ops, input string tag);
        logic         ev;
        logic [N-1:0] es;
        string        et;
        @(negedge clk);
        if (cyc >= LAT) begin
            ev = h_vld[(cyc - LAT) % HW];
            es = h_sum[(cyc - LAT) % HW];
            et = h_tag[(cyc - LAT) % HW];
        end else begin
            ev = 1'b0; es = '0; et = "R6";
        end
        checks++;
        if (out_vld !== ev) begin
            fails++;
            $display("FAIL %s R3 valid at cycle %0d: got %b expected %b", et, cyc, out_vld, ev);
        end
        if (ev && out_vld === 1'b1) begin
            checks++;
            if (out_sum !== es) begin
                fails++;
                $display("FAIL %s sum at cycle %0d: got %0d expected %0d", et, cyc, out_sum, es);
            end
        end
        in_vld = v;
        in_ops = ops;
        h_vld[cyc % HW] = v & rst_n;
        h_sum[cyc % HW] = ref_sum(ops);
        h_tag[cyc % HW] = tag;
        cyc++;
    endtask

    initial begin
        logic [K*M-1:0] o;
        // R6: reset holds the output invalid even with valid inputs
        step(1'b1, rnd_ops(), "R6");
        step(1'b1, rnd_ops(), "R6");
        step(1'b0, rnd_ops(), "R6");
        rst_n = 1'b1;
        step(1'b0, rnd_ops(), "R6");
        step(1'b0, rnd_ops(), "R6");

        // R2: a single pulse appears exactly LAT cycles later
        o = '0;
        o[0 +: M] = 8'd37;
        o[5*M +: M] = 8'd200;
        step(1'b1, o, "R2");
        for (int i = 0; i < LAT + 2; i++) step(1'b0, '0, "R2");

        // R5: one nonzero operand at a time locates each slot
        for (int i = 0; i < K; i++) begin
            o = '0;
            o[i*M +: M] = M'((i + 1) * 17 + 3);
            step(1'b1, o, "R5");
        end

        // R4: all operands at full scale wrap to 506
        step(1'b1, {K*M{1'b1}}, "R4");
        for (int i = 0; i < 8; i++) begin
            o = '0;
            for (int k = 0; k < K; k++) o[k*M +: M] = M'(200 + $urandom % 56);
            step(1'b1, o, "R4");
        end

        // R1/R7: back-to-back random operands every cycle
        for (int i = 0; i < 150; i++) step(1'b1, rnd_ops(), "R1/R7");

        // R8: gaps carrying junk data must stay invisible
        for (int i = 0; i < 100; i++) step(1'($urandom % 2), rnd_ops(), "R8");

        // R3: drain the pipeline
        for (int i = 0; i < LAT + 2; i++) step(1'b0, rnd_ops(), "R3");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired at cycle %0d: got hang expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule